// File: doc/BRIEF.md
# Serial Clock Generator with Two Cascaded Dividers

This block produces the serial clock for an SPI master from the main clock. The clock passes through two divider stages in a row. The first is a power-of-two prescaler, chosen by a 2-bit select, that divides by 2, 4, 8 or 16. The second stage divides by twice the value of a 6-bit baud field plus one. Both stages are built as clock-enable counters inside the main clock domain. The serial clock comes out of a register that toggles, so no derived clock is ever created.

Beside the clock, the block gives the shift logic two strobes, each one cycle long. The leading strobe marks the cycle in which the serial clock leaves its idle level. The trailing strobe marks the cycle in which it returns to idle. The polarity input selects the idle level.

Firmware programs the divider fields. Baud values below the legal floor are raised to the floor. A new setting is adopted only at the end of a full serial-clock period, so a setting change cannot produce a runt pulse.

Top module: `spi_sclk_gen`

## Requirements
- R1: After reset, with the enable low and the polarity at 0, the serial clock reads 0 and both strobes read 0.
- R2: While enabled, the serial clock changes level every H main-clock cycles, where H = (2 << divSel) × (baudDiv + 1). The first change comes H cycles after the first clock edge at which the enable is sampled high.
- R3: The fastest setting, divSel = 0 and baudDiv = 4, gives a full serial period of 20 main-clock cycles (H = 10).
- R4: The slowest setting, divSel = 3 and baudDiv = 63, gives a full serial period of 2048 main-clock cycles (H = 1024).
- R5: A baudDiv value below 4 acts exactly like 4, so the serial clock never runs faster than the fastest legal rate.
- R6: The cpol input sets the idle level of the serial clock. leadStrobe is high in the cycle the clock first shows the non-idle level (~cpol). trailStrobe is high in the cycle it returns to cpol.
- R7: While the enable is low, both divider counters are held cleared and the serial clock sits at cpol. No strobe fires in this state. When the enable goes high again, a fresh period starts and follows the R2 timing.
- R8: A change to divSel or baudDiv while enabled is adopted only at the trailing edge that ends the current period. The next period uses the new setting from its start.
- R9: Each strobe lasts exactly one cycle. leadStrobe and trailStrobe are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the dividers; when low, clears them and parks the serial clock at idle |
| divSel | input | 2 | Prescaler select: divide by 2 << divSel |
| baudDiv | input | 6 | Baud field: the second stage divides by 2 × (baudDiv + 1); values below 4 act as 4 |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock, registered |
| leadStrobe | output | 1 | One-cycle pulse when sclk leaves the idle level |
| trailStrobe | output | 1 | One-cycle pulse when sclk returns to the idle level |

## Verification
The assertions check these properties on every cycle:
- A low enable parks the clock at the idle level and keeps both strobes silent.
- The strobes are single-cycle and mutually exclusive.
- A leading strobe always comes with a real level change.
- No half period is shorter than the ten cycles of the fastest legal rate, which also covers the clamp of small baud values.

The scoreboard checks what a per-cycle property cannot. It checks the exact cycle of every edge for each prescaler and baud setting. It checks that a setting change made in the middle of a period is deferred to the next period. It checks that a period cut short by dropping the enable restarts cleanly.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;
  // Per-cycle events sent from the divider control to the clock register
  typedef struct packed {
    logic toggle;  // a half period ends in this cycle
    logic lead;    // clock is leaving the idle level
    logic trail;   // clock is returning to the idle level
  } sclk_evt_t;
endpackage

// File: rtl/sclk_div_ctrl.sv
module sclk_div_ctrl
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W   = 2,
  parameter int BRG_W   = 6,
  parameter int BRG_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] divSel,
  input  logic [BRG_W-1:0] baudDiv,
  output sclk_evt_t        evt
);
  // Widest prescale ratio is 2 << (2**DIV_W - 1) = 2**(2**DIV_W)
  localparam int PRE_W = 1 << DIV_W;

  logic [DIV_W-1:0] divAct;
  logic [BRG_W-1:0] brgAct;
  logic [PRE_W-1:0] preCnt;
  logic [BRG_W-1:0] baudCnt;
  logic             phase;    // 0: idle-level half, 1: active-level half

  logic [PRE_W:0]   preSpan;
  logic [PRE_W-1:0] preLimit;
  logic [BRG_W-1:0] brgClamp;
  logic             preTick;
  logic             halfDone;
  logic             cfgLoad;

  assign preSpan  = (PRE_W+1)'(2) << divAct;
  assign preLimit = PRE_W'(preSpan - 1'b1);
  assign brgClamp = (baudDiv < BRG_W'(BRG_MIN)) ? BRG_W'(BRG_MIN) : baudDiv;
  assign preTick  = (preCnt == preLimit);
  assign halfDone = preTick && (baudCnt == brgAct);
  // Settings are adopted only while idle or when a full period closes
  assign cfgLoad  = !enable || (halfDone && phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divAct  <= '0;
      brgAct  <= BRG_W'(BRG_MIN);
      preCnt  <= '0;
      baudCnt <= '0;
      phase   <= 1'b0;
    end else begin
      if (cfgLoad) begin
        divAct <= divSel;
        brgAct <= brgClamp;
      end
      if (!enable) begin
        preCnt  <= '0;
        baudCnt <= '0;
        phase   <= 1'b0;
      end else begin
        preCnt <= preTick ? '0 : preCnt + 1'b1;
        if (halfDone) begin
          baudCnt <= '0;
          phase   <= ~phase;
        end else if (preTick) begin
          baudCnt <= baudCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    evt.toggle = halfDone;
    evt.lead   = halfDone && !phase;
    evt.trail  = halfDone && phase;
  end
endmodule

// File: rtl/sclk_out_reg.sv
module sclk_out_reg
  import spi_sclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      cpol,
  input  sclk_evt_t evt,
  output logic      sclk,
  output logic      leadStrobe,
  output logic      trailStrobe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk        <= 1'b0;
      leadStrobe  <= 1'b0;
      trailStrobe <= 1'b0;
    end else if (!enable) begin
      sclk        <= cpol;
      leadStrobe  <= 1'b0;
      trailStrobe <= 1'b0;
    end else begin
      if (evt.toggle) sclk <= ~sclk;
      leadStrobe  <= evt.lead;
      trailStrobe <= evt.trail;
    end
  end
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int DIV_W   = 2,
  parameter int BRG_W   = 6,
  parameter int BRG_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] divSel,
  input  logic [BRG_W-1:0] baudDiv,
  input  logic             cpol,
  output logic             sclk,
  output logic             leadStrobe,
  output logic             trailStrobe
);
  sclk_evt_t evt;

  sclk_div_ctrl #(
    .DIV_W  (DIV_W),
    .BRG_W  (BRG_W),
    .BRG_MIN(BRG_MIN)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .divSel (divSel),
    .baudDiv(baudDiv),
    .evt    (evt)
  );

  sclk_out_reg u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cpol       (cpol),
    .evt        (evt),
    .sclk       (sclk),
    .leadStrobe (leadStrobe),
    .trailStrobe(trailStrobe)
  );
endmodule

// File: rtl/spi_sclk_gen_chk.sv
module spi_sclk_gen_chk #(
  parameter int MIN_HALF = 10
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic cpol,
  input logic sclk,
  input logic leadStrobe,
  input logic trailStrobe
);
  // Number of cycles since the last edge strobe while enabled (saturating)
  logic [10:0] runLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) runLen <= '0;
    else if (!enable) runLen <= '0;
    else if (leadStrobe || trailStrobe) runLen <= 11'd1;
    else if (runLen != '1) runLen <= runLen + 1'b1;
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (sclk == $past(cpol)));  // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(leadStrobe || trailStrobe));  // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(leadStrobe && trailStrobe));  // R9
  AST_LEAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    leadStrobe |=> !leadStrobe);  // R9
  AST_TRAIL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trailStrobe |=> !trailStrobe);  // R9
  AST_LEAD_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    leadStrobe |-> (sclk != $past(sclk)));  // R6
  AST_MIN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (leadStrobe || trailStrobe) |-> (runLen >= 11'(MIN_HALF)));  // R5
endmodule

bind spi_sclk_gen spi_sclk_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .cpol       (cpol),
  .sclk       (sclk),
  .leadStrobe (leadStrobe),
  .trailStrobe(trailStrobe)
);

// File: tb/spi_sclk_gen_bench.sv
module spi_sclk_gen_bench;
  typedef struct {
    int    cyc;
    bit    isLead;
    bit    pol;
    string req;
  } edge_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] divSel = '0;
  logic [5:0] baudDiv = 6'd4;
  logic       cpol = 1'b0;
  logic       sclk, leadStrobe, trailStrobe;

  int checks = 0;
  int failures = 0;
  int cycNum = 0;
  bit finished = 0;
  edge_item_t expQ[$];

  always #10 clk = ~clk;  // 50 MHz

  spi_sclk_gen u_spi_sclk_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .divSel     (divSel),
    .baudDiv    (baudDiv),
    .cpol       (cpol),
    .sclk       (sclk),
    .leadStrobe (leadStrobe),
    .trailStrobe(trailStrobe)
  );

  // Counts the clock edges at which the enable was sampled high
  always @(posedge clk) cycNum <= enable ? cycNum + 1 : 0;

  // Monitor: every strobe must match the next expected edge
  always @(negedge clk) begin
    if (rst_n && (leadStrobe || trailStrobe)) begin
      checks++;
      if (leadStrobe && trailStrobe) begin
        failures++;
        $display("FAIL R9 both strobes high: actual lead=%0b trail=%0b expected one", leadStrobe, trailStrobe);
      end else if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R7 unexpected strobe at cycle %0d: actual lead=%0b trail=%0b expected none",
                 cycNum, leadStrobe, trailStrobe);
      end else begin
        edge_item_t it;
        it = expQ.pop_front();
        if (cycNum != it.cyc || leadStrobe != it.isLead ||
            sclk != (it.isLead ? ~it.pol : it.pol)) begin
          failures++;
          $display("FAIL %s edge: actual cyc=%0d lead=%0b sclk=%0b expected cyc=%0d lead=%0b sclk=%0b",
                   it.req, cycNum, leadStrobe, sclk, it.cyc, it.isLead,
                   it.isLead ? ~it.pol : it.pol);
        end
      end
    end
  end

  task automatic checkVal(input string req, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s: actual %0b expected %0b", req, actual, expected);
    end
  endtask

  function automatic int halfLen(input int d, input int b);
    int eb;
    eb = (b < 4) ? 4 : b;
    return (2 << d) * (eb + 1);
  endfunction

  task automatic pushEdges(input int h, input int firstK, input int lastK, input int base,
                           input bit pol, input string req);
    for (int k = firstK; k <= lastK; k++) begin
      edge_item_t it;
      it.cyc = base + (k - firstK + 1) * h;
      it.isLead = (k % 2) == 1;
      it.pol = pol;
      it.req = req;
      expQ.push_back(it);
    end
  endtask

  task automatic drainAndStop();
    while (expQ.size() != 0) @(negedge clk);
    enable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Driver: program a setting, predict the edges, run the requested periods
  task automatic runBurst(input int d, input int b, input bit pol, input int periods, input string req);
    @(negedge clk);
    divSel = 2'(d);
    baudDiv = 6'(b);
    cpol = pol;
    repeat (2) @(negedge clk);
    checkVal({req, " idle level before start"}, sclk, pol);
    pushEdges(halfLen(d, b), 1, 2 * periods, 0, pol, req);
    enable = 1'b1;
    drainAndStop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checkVal("R1 sclk after reset", sclk, 1'b0);
    checkVal("R1 leadStrobe after reset", leadStrobe, 1'b0);
    checkVal("R1 trailStrobe after reset", trailStrobe, 1'b0);

    cpol = 1'b1;
    @(negedge clk);
    checkVal("R6 idle follows cpol=1", sclk, 1'b1);

    runBurst(0, 4, 1'b0, 2, "R3");    // H = 10
    runBurst(1, 7, 1'b0, 2, "R2");    // H = 32
    runBurst(2, 10, 1'b1, 2, "R6");   // H = 88, idle high
    runBurst(3, 63, 1'b0, 1, "R4");   // H = 1024
    runBurst(0, 2, 1'b0, 2, "R5");    // acts as 4: H = 10
    runBurst(2, 0, 1'b1, 1, "R5");    // acts as 4: H = 40

    // R8: change the baud field in the first half of a period
    @(negedge clk);
    divSel = 2'd0; baudDiv = 6'd4; cpol = 1'b0;
    repeat (2) @(negedge clk);
    pushEdges(10, 1, 2, 0, 1'b0, "R8");
    pushEdges(20, 3, 4, 20, 1'b0, "R8");
    enable = 1'b1;
    while (cycNum != 5) @(negedge clk);
    baudDiv = 6'd9;
    drainAndStop();

    // R8: change the prescaler in the second half of a period
    @(negedge clk);
    divSel = 2'd0; baudDiv = 6'd4;
    repeat (2) @(negedge clk);
    pushEdges(10, 1, 2, 0, 1'b0, "R8");
    pushEdges(40, 3, 4, 20, 1'b0, "R8");
    enable = 1'b1;
    while (cycNum != 15) @(negedge clk);
    divSel = 2'd2;
    drainAndStop();

    // R7: drop the enable mid-period, then restart fresh
    @(negedge clk);
    divSel = 2'd1; baudDiv = 6'd4; cpol = 1'b1;
    repeat (2) @(negedge clk);
    pushEdges(20, 1, 1, 0, 1'b1, "R7");
    enable = 1'b1;
    while (cycNum != 30) @(negedge clk);
    checkVal("R7 sclk active mid-period", sclk, 1'b0);
    enable = 1'b0;
    @(negedge clk);
    checkVal("R7 sclk parked at idle", sclk, 1'b1);
    repeat (40) @(negedge clk);
    checkVal("R7 sclk still idle", sclk, 1'b1);
    checkVal("R7 no pending edges", expQ.size() == 0, 1'b1);
    runBurst(1, 4, 1'b1, 1, "R7");

    checkVal("R9 queue drained", expQ.size() == 0, 1'b1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule